// File: doc/BRIEF.md
# Cascaded Interrupt Line Controller

This block gathers thirty-two level-sensitive interrupt requests and forwards them to a primary interrupt controller. Each request is captured into a raw level register on every clock edge. A software-controlled enable mask picks which captured requests are ORed into one combined request. That combined request is presented on upstream line 31.

A second register lets requests 21 to 30 bypass the mask. When a line's bit is set in that register, the line drives the upstream line with the same number directly. Lines whose bit is clear are held low. The remaining upstream lines are always held low.

Software reaches the registers through a 32-bit APB-style port with no wait states. The port decodes a 4 KB window by word index. Index writes are set/clear style, so no read-modify-write is needed. Raw level, outputs and register updates all take effect on the same clock edge.

Top module: `irqc_cascade`

## Requirements
- R1: After a synchronous reset, the raw level, enable mask and passthrough registers read zero and every bit of `irq_up` is low.
- R2: Raw level bit i equals `irq_in[i]` as sampled at the most recent clock edge; it reads back at word index 1 (byte offset 0x004).
- R3: `irq_up[31]` is high exactly when (raw level AND enable mask) is nonzero, updated on the same edge as the raw level; that masked value reads at index 0.
- R4: A write to index 2 ORs the written data into the enable mask; a write to index 3 clears the mask bits that are 1 in the data; index 2 reads the mask.
- R5: A read of index 4 returns raw level bit 0 in bit 0 and zeros elsewhere; a nonzero write to index 4 sets only mask bit 0; a nonzero write to index 5 clears only mask bit 0; a zero write to either leaves the mask unchanged.
- R6: A write to index 8 ORs (data AND 0x7FE00000) into the passthrough register, so only bits 21..30 can ever be set; index 8 reads the passthrough register.
- R7: A write to index 9 clears the passthrough bits that are 1 in the data.
- R8: For each line i in 21..30, `irq_up[i]` equals raw level bit i while passthrough bit i is set, and is low while it is clear. This holds after an input change and on the edge that completes a passthrough write.
- R9: `irq_up[20:0]` is low at all times.
- R10: The word index is `paddr[11:2]`, and `paddr[1:0]` is ignored. Indices 3, 5, 6, 7 and 9 through 1023 read 0. Writes to indices 0, 1, 6, 7 and 10 through 1023 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive interrupt requests |
| psel | input | 1 | Register port select |
| penable | input | 1 | Register port access phase |
| pwrite | input | 1 | High for a write access |
| paddr | input | 12 | Byte address within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| irq_up | output | 32 | Upstream request lines; bit 31 combined, bits 21..30 passthrough |

## Verification
The combined output is tried with a one-hot mask walked across all 32 positions. At each position it sees both a matching one-hot input and the inverted input, which separates a correct AND-then-OR from a swapped bit or an OR of the wrong vector. The passthrough path is swept with a one-hot input over every line while all passthrough bits are enabled, which shows that exactly lines 21 to 30 forward and lines 0 to 20 never do. A final case enables passthrough while the inputs are already high, which checks that the output changes on the write edge itself. The software-interrupt indices are driven with zero and with nonzero data whose bit 0 is clear, which catches a decode that uses the data bit instead of the nonzero test.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Word indices of the register port (byte offset >> 2)
  localparam int unsigned IDX_STATUS   = 0;
  localparam int unsigned IDX_RAW      = 1;
  localparam int unsigned IDX_EN_SET   = 2;
  localparam int unsigned IDX_EN_CLR   = 3;
  localparam int unsigned IDX_SOFT_SET = 4;
  localparam int unsigned IDX_SOFT_CLR = 5;
  localparam int unsigned IDX_PT_SET   = 8;
  localparam int unsigned IDX_PT_CLR   = 9;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int N_IRQ = 32,
  parameter int IDX_W = 10,
  parameter int PT_LO = 21,
  parameter int PT_HI = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [N_IRQ-1:0] wr_data,
  output logic [N_IRQ-1:0] mask_q,
  output logic [N_IRQ-1:0] pass_q,
  output logic [N_IRQ-1:0] mask_d,
  output logic [N_IRQ-1:0] pass_d
);
  import irqc_pkg::*;

  function automatic logic [N_IRQ-1:0] span_mask();
    logic [N_IRQ-1:0] m;
    m = '0;
    for (int b = PT_LO; b <= PT_HI; b++) m[b] = 1'b1;
    return m;
  endfunction

  localparam logic [N_IRQ-1:0] PT_MASK = span_mask();
  localparam logic [IDX_W-1:0] I_EN_SET   = IDX_W'(IDX_EN_SET);
  localparam logic [IDX_W-1:0] I_EN_CLR   = IDX_W'(IDX_EN_CLR);
  localparam logic [IDX_W-1:0] I_SOFT_SET = IDX_W'(IDX_SOFT_SET);
  localparam logic [IDX_W-1:0] I_SOFT_CLR = IDX_W'(IDX_SOFT_CLR);
  localparam logic [IDX_W-1:0] I_PT_SET   = IDX_W'(IDX_PT_SET);
  localparam logic [IDX_W-1:0] I_PT_CLR   = IDX_W'(IDX_PT_CLR);

  logic data_nz;
  assign data_nz = |wr_data;

  always_comb begin
    mask_d = mask_q;
    pass_d = pass_q;
    if (wr_en) begin
      case (wr_idx)
        I_EN_SET:   mask_d = mask_q | wr_data;
        I_EN_CLR:   mask_d = mask_q & ~wr_data;
        I_SOFT_SET: if (data_nz) mask_d[0] = 1'b1;
        I_SOFT_CLR: if (data_nz) mask_d[0] = 1'b0;
        I_PT_SET:   pass_d = pass_q | (wr_data & PT_MASK);
        I_PT_CLR:   pass_d = pass_q & ~wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pass_q <= '0;
    end else begin
      mask_q <= mask_d;
      pass_q <= pass_d;
    end
  end

  logic is_known;
  assign is_known = (wr_idx == I_EN_SET) || (wr_idx == I_EN_CLR) ||
                    (wr_idx == I_SOFT_SET) || (wr_idx == I_SOFT_CLR) ||
                    (wr_idx == I_PT_SET) || (wr_idx == I_PT_CLR);

  a_r6_pass_range: assert property (@(posedge clk) disable iff (rst)
    (pass_q & ~PT_MASK) == '0);

  a_r4_set_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == I_EN_SET) |=> ((mask_q & $past(wr_data)) == $past(wr_data)));

  a_r4_clr_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == I_EN_CLR) |=> ((mask_q & $past(wr_data)) == '0));

  a_r5_zero_soft_noop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == I_SOFT_SET || wr_idx == I_SOFT_CLR) && !data_nz)
      |=> $stable(mask_q));

  a_r7_pt_clr_lands: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == I_PT_CLR) |=> ((pass_q & $past(wr_data)) == '0));

  a_r10_unlisted_noop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !is_known) |=> ($stable(mask_q) && $stable(pass_q)));
endmodule

// File: rtl/irqc_lines.sv
module irqc_lines #(
  parameter int N_IRQ    = 32,
  parameter int COMB_IDX = 31,
  parameter int PT_LO    = 21,
  parameter int PT_HI    = 30
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] mask_d,
  input  logic [N_IRQ-1:0] pass_d,
  input  logic [N_IRQ-1:0] mask_q,
  input  logic [N_IRQ-1:0] pass_q,
  output logic [N_IRQ-1:0] raw_q,
  output logic [N_IRQ-1:0] irq_up
);
  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= irq_in;
  end

  a_r2_raw_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (raw_q == $past(irq_in)));

  for (genvar i = 0; i < N_IRQ; i++) begin : g_line
    if (i == COMB_IDX) begin : g_comb
      always_ff @(posedge clk) begin
        if (rst) irq_up[i] <= 1'b0;
        else     irq_up[i] <= |(irq_in & mask_d);
      end
      a_r3_comb_level: assert property (@(posedge clk) disable iff (rst)
        irq_up[i] == |(raw_q & mask_q));
    end else if (i >= PT_LO && i <= PT_HI) begin : g_pass
      always_ff @(posedge clk) begin
        if (rst) irq_up[i] <= 1'b0;
        else     irq_up[i] <= pass_d[i] & irq_in[i];
      end
      a_r8_pass_follows: assert property (@(posedge clk) disable iff (rst)
        pass_q[i] |-> (irq_up[i] == raw_q[i]));
      a_r8_pass_blocked: assert property (@(posedge clk) disable iff (rst)
        !pass_q[i] |-> !irq_up[i]);
    end else begin : g_quiet
      always_ff @(posedge clk) begin
        irq_up[i] <= 1'b0;
      end
      a_r9_quiet_low: assert property (@(posedge clk) disable iff (rst)
        !irq_up[i]);
    end
  end
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux #(
  parameter int N_IRQ = 32,
  parameter int IDX_W = 10
) (
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [N_IRQ-1:0] raw_q,
  input  logic [N_IRQ-1:0] mask_q,
  input  logic [N_IRQ-1:0] pass_q,
  output logic [N_IRQ-1:0] rd_data
);
  import irqc_pkg::*;

  localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(IDX_STATUS);
  localparam logic [IDX_W-1:0] I_RAW    = IDX_W'(IDX_RAW);
  localparam logic [IDX_W-1:0] I_MASK   = IDX_W'(IDX_EN_SET);
  localparam logic [IDX_W-1:0] I_SOFT   = IDX_W'(IDX_SOFT_SET);
  localparam logic [IDX_W-1:0] I_PT     = IDX_W'(IDX_PT_SET);

  always_comb begin
    rd_data = '0;
    case (rd_idx)
      I_STATUS: rd_data = raw_q & mask_q;
      I_RAW:    rd_data = raw_q;
      I_MASK:   rd_data = mask_q;
      I_SOFT:   rd_data[0] = raw_q[0];
      I_PT:     rd_data = pass_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade #(
  parameter int N_IRQ    = 32,
  parameter int ADDR_W   = 12,
  parameter int COMB_IDX = 31,
  parameter int PT_LO    = 21,
  parameter int PT_HI    = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IRQ-1:0]  irq_in,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [N_IRQ-1:0]  pwdata,
  output logic [N_IRQ-1:0]  prdata,
  output logic [N_IRQ-1:0]  irq_up
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             wr_en;
  logic [N_IRQ-1:0] mask_q, pass_q, mask_d, pass_d, raw_q;
  logic [1:0]       unused_byte_lane;

  assign idx              = paddr[ADDR_W-1:2];
  assign unused_byte_lane = paddr[1:0];
  assign wr_en            = psel & penable & pwrite;

  irqc_regs #(.N_IRQ(N_IRQ), .IDX_W(IDX_W), .PT_LO(PT_LO), .PT_HI(PT_HI)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(idx), .wr_data(pwdata),
    .mask_q(mask_q), .pass_q(pass_q), .mask_d(mask_d), .pass_d(pass_d)
  );

  irqc_lines #(.N_IRQ(N_IRQ), .COMB_IDX(COMB_IDX), .PT_LO(PT_LO), .PT_HI(PT_HI)) lines_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask_d(mask_d), .pass_d(pass_d),
    .mask_q(mask_q), .pass_q(pass_q), .raw_q(raw_q), .irq_up(irq_up)
  );

  irqc_rdmux #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) rdmux_i (
    .rd_idx(idx), .raw_q(raw_q), .mask_q(mask_q), .pass_q(pass_q), .rd_data(prdata)
  );
endmodule

// File: tb/irqc_cascade_tb.sv
module irqc_cascade_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, irq_up;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_raw = '0, m_mask = '0, m_pass = '0;
  localparam logic [31:0] PT = 32'h7FE0_0000;

  always #5 clk = ~clk;

  irqc_cascade dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_up(irq_up)
  );

  function automatic logic [31:0] exp_up(input logic [31:0] r, m, p);
    logic [31:0] v;
    v = r & p & PT;
    v[31] = |(r & m);
    return v;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_in(input logic [31:0] v);
    @(negedge clk);
    irq_in = v;
    m_raw = v;
    @(negedge clk);
  endtask

  task automatic wr_addr(input logic [11:0] a, input logic [31:0] d);
    logic [9:0] ix;
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    ix = a[11:2];
    case (ix)
      10'd2: m_mask = m_mask | d;
      10'd3: m_mask = m_mask & ~d;
      10'd4: if (d != 0) m_mask[0] = 1'b1;
      10'd5: if (d != 0) m_mask[0] = 1'b0;
      10'd8: m_pass = m_pass | (d & PT);
      10'd9: m_pass = m_pass & ~d;
      default: ;
    endcase
  endtask

  task automatic wr(input int ix, input logic [31:0] d);
    wr_addr({ix[9:0], 2'b00}, d);
  endtask

  task automatic rd(input int ix, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; paddr = {ix[9:0], 2'b00}; penable = 1'b0;
    @(negedge clk);
    penable = 1'b1;
    #1 d = prdata;
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    irq_in = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    irq_in = '0;
    // R1: reset state
    check("R1 irq_up", irq_up, 32'h0);
    rd(1, d); check("R1 raw", d, 32'h0);
    rd(2, d); check("R1 mask", d, 32'h0);
    rd(8, d); check("R1 pass", d, 32'h0);
    rd(0, d); check("R1 status", d, 32'h0);

    // R2: raw level walking one
    for (int i = 0; i < 32; i++) begin
      set_in(32'h1 << i);
      rd(1, d); check("R2 raw walk", d, 32'h1 << i);
      check("R2 no output unmasked", irq_up, 32'h0);
    end
    set_in(32'hA5A5_5A5A);
    rd(1, d); check("R2 raw pattern", d, 32'hA5A5_5A5A);

    // R4: set and clear of the mask
    wr(2, 32'h0000_00F0);
    wr(2, 32'h0F00_0000);
    rd(2, d); check("R4 or-set", d, 32'h0F00_00F0);
    wr(3, 32'h0000_0030);
    rd(2, d); check("R4 clear", d, 32'h0F00_00C0);
    wr(3, 32'hFFFF_FFFF);
    rd(2, d); check("R4 clear all", d, 32'h0);

    // R3: one-hot mask sweep, matching and inverted inputs
    for (int i = 0; i < 32; i++) begin
      wr(3, 32'hFFFF_FFFF);
      wr(2, 32'h1 << i);
      set_in(32'h1 << i);
      check("R3 comb hit", irq_up, exp_up(m_raw, m_mask, m_pass));
      check("R3 comb hit bit31", {31'b0, irq_up[31]}, 32'h1);
      rd(0, d); check("R3 status hit", d, 32'h1 << i);
      set_in(~(32'h1 << i));
      check("R3 comb miss", irq_up, 32'h0);
      rd(0, d); check("R3 status miss", d, 32'h0);
    end
    wr(3, 32'hFFFF_FFFF);

    // R5: software interrupt indices
    set_in(32'hFFFF_FFFF);
    rd(4, d); check("R5 read bit0 set", d, 32'h1);
    set_in(32'hFFFF_FFFE);
    rd(4, d); check("R5 read bit0 clear", d, 32'h0);
    wr(4, 32'h0);
    rd(2, d); check("R5 zero set noop", d, 32'h0);
    wr(4, 32'h0000_0100);
    rd(2, d); check("R5 nonzero set", d, 32'h1);
    wr(5, 32'h0);
    rd(2, d); check("R5 zero clr noop", d, 32'h1);
    wr(2, 32'h0000_0006);
    wr(5, 32'h8000_0000);
    rd(2, d); check("R5 nonzero clr", d, 32'h6);
    wr(3, 32'hFFFF_FFFF);

    // R6, R7: passthrough register
    wr(8, 32'hFFFF_FFFF);
    rd(8, d); check("R6 set limited", d, 32'h7FE0_0000);
    wr(9, 32'h0020_0000);
    rd(8, d); check("R7 clear one", d, 32'h7FC0_0000);
    wr(9, 32'hFFFF_FFFF);
    rd(8, d); check("R7 clear all", d, 32'h0);

    // R8, R9: passthrough sweep
    wr(8, 32'hFFFF_FFFF);
    for (int i = 0; i < 32; i++) begin
      set_in(32'h1 << i);
      check("R8 pass sweep", irq_up, (32'h1 << i) & PT);
    end
    set_in(32'hFFFF_FFFF);
    check("R9 low lines", irq_up & 32'h001F_FFFF, 32'h0);
    check("R8 all pass", irq_up, 32'h7FE0_0000);
    wr(9, 32'hFFFF_FFFF);
    check("R8 blocked after clear", irq_up, 32'h0);
    wr(8, 32'h0040_0000);
    check("R8 on write edge", irq_up, 32'h0040_0000);
    wr(2, 32'h0000_0001);
    check("R9 with comb", irq_up, exp_up(m_raw, m_mask, m_pass));
    set_in(32'h0);
    check("R8 input fall", irq_up, 32'h0);

    // R10: unlisted indices and byte offset
    wr(6, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(10, 32'hFFFF_FFFF);
    wr(1023, 32'hFFFF_FFFF);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    rd(2, d); check("R10 mask untouched", d, 32'h1);
    rd(8, d); check("R10 pass untouched", d, 32'h0040_0000);
    set_in(32'hFFFF_FFFF);
    rd(3, d); check("R10 read idx3", d, 32'h0);
    rd(5, d); check("R10 read idx5", d, 32'h0);
    rd(6, d); check("R10 read idx6", d, 32'h0);
    rd(9, d); check("R10 read idx9", d, 32'h0);
    rd(1023, d); check("R10 read idx1023", d, 32'h0);
    wr_addr(12'h00B, 32'h0000_0010);
    rd(2, d); check("R10 byte offset ignored", d, 32'h11);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule